// File: doc/BRIEF.md
# CAN Receive Filter and Transmit Buffer Arbiter

This block sits between a CAN protocol engine and a bank of fifteen message buffers. Each buffer is set up through a plain configuration port as off, as a receiver or as a pending transmitter. Every buffer holds an identifier, an extended-format flag, a remote-request flag and a 4-bit transmit priority. A receiver also holds an auto-answer flag. When the engine presents a received frame, the block compares the frame key against every receiver in a single cycle. Buffers 0 to 13 share one acceptance mask. Buffer 14 has its own mask and acts as a catch-all. The block then stores the frame in the winning buffer, together with a 16-bit time stamp taken from a free-running counter.

On the transmit side the block offers one pending buffer at a time to the engine. It picks the buffer with the numerically lowest priority value and breaks ties toward the lower index. The engine accepts the offer with a valid/ready handshake and later reports either a completed frame or lost arbitration. After either event the choice is made again. Remote frames are handled by changing buffer roles. A transmitter that sends a remote request turns into a receiver for the answering data frame. A receiver with auto-answer set turns into a pending transmitter when a matching remote frame arrives.

Two streams use valid/ready. On the receive stream, `rx_ready` is low in any cycle where a configuration write happens, so the engine must hold its frame until `rx_ready` is high. Otherwise a frame is taken in the cycle it is valid. On the transmit stream, `tx_valid` stays high with stable contents until `tx_ready` is seen. It then stays low until the engine pulses `tx_done` or `tx_lost`.

Top module: `can_msgbuf_arbiter`

## Requirements
- R1: After reset, every buffer is off and not full, no overrun is flagged, `tx_valid` is 0, `rx_res_valid` is 0, and the time stamp is 0.
- R2: A frame key is {IDE at bit 30, RTR at bit 29, identifier at bits 28:0}. A standard identifier occupies bits 10:0 with bits 28:11 zero. A mask bit of 1 compares that key bit and 0 ignores it. A receiver among buffers 0–13 matches when all bits selected by `mask_main` equal its stored key.
- R3: When several receivers among buffers 0–13 match, the lowest index takes the frame. The result appears on `rx_res_valid`/`rx_res_hit`/`rx_res_buf` in the cycle after the handshake.
- R4: Buffer 14 is matched under `mask_basic` and takes a frame only when none of buffers 0–13 match.
- R5: A frame that matches no receiver gives `rx_res_valid`=1 with `rx_res_hit`=0 and leaves all buffer state unchanged.
- R6: A frame stored into a receiver that is already full overwrites its contents and sets that buffer's overrun flag.
- R7: `tx_buf` names the pending transmitter with the smallest priority value, with ties going to the lower index. `tx_valid` is 1 only when a transmitter is pending and no frame is in flight.
- R8: On `tx_done` the in-flight buffer stops pending, turns off and captures the time stamp. On `tx_lost` it stays pending and the choice is made again.
- R9: A transmitter whose RTR flag is 1 becomes an empty receiver with RTR 0 and the same identifier after `tx_done`.
- R10: A receiver with auto-answer set that takes a frame with RTR 1 becomes a pending transmitter with RTR 0 instead of becoming full.
- R11: The time stamp counts up by one every clock cycle and wraps around. A stored frame captures the value present in its handshake cycle.
- R12: `rx_ready` is 0 in any cycle with `cfg_we` high, and a frame offered in that cycle has no effect.
- R13: A release (`rel_we`) clears the full and overrun flags of the chosen buffer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_idx | input | 4 | Buffer being configured |
| cfg_mode | input | 2 | 0 off, 1 receive, 2 transmit, 3 off |
| cfg_id | input | 29 | Identifier to store |
| cfg_ide | input | 1 | Extended-format flag to store |
| cfg_rtr | input | 1 | Remote-request flag to store |
| cfg_prio | input | 4 | Transmit priority (0 is most urgent) |
| cfg_auto | input | 1 | Auto-answer remote frames |
| rel_we | input | 1 | Release strobe for a read receiver |
| rel_idx | input | 4 | Buffer being released |
| mask_main | input | 31 | Acceptance mask for buffers 0–13 |
| mask_basic | input | 31 | Acceptance mask for buffer 14 |
| rx_valid | input | 1 | Received frame valid |
| rx_ready | output | 1 | Filter can take a frame |
| rx_id | input | 29 | Received identifier |
| rx_ide | input | 1 | Received extended-format flag |
| rx_rtr | input | 1 | Received remote-request flag |
| rx_res_valid | output | 1 | Filter result valid (one cycle) |
| rx_res_hit | output | 1 | Frame was stored |
| rx_res_buf | output | 4 | Buffer that took the frame |
| tx_valid | output | 1 | A transmit frame is offered |
| tx_ready | input | 1 | Engine takes the offer |
| tx_buf | output | 4 | Offered buffer |
| tx_id | output | 29 | Offered identifier |
| tx_ide | output | 1 | Offered extended-format flag |
| tx_rtr | output | 1 | Offered remote-request flag |
| tx_done | input | 1 | In-flight frame completed |
| tx_lost | input | 1 | In-flight frame lost arbitration |
| ts_now | output | 16 | Free-running time stamp |
| rd_idx | input | 4 | Buffer selected for readout |
| rd_id | output | 29 | Identifier of selected buffer |
| rd_ide | output | 1 | Extended flag of selected buffer |
| rd_rtr | output | 1 | Remote flag of selected buffer |
| rd_stamp | output | 16 | Captured stamp of selected buffer |
| buf_rx_full | output | 15 | Per-buffer full flags |
| buf_ovr | output | 15 | Per-buffer overrun flags |
| buf_tx_pend | output | 15 | Per-buffer pending-transmit flags |

## Verification
The hardest state to reach from the ports is a chain of role changes. A remote request must complete and then be answered by a data frame that lands in the same buffer. An auto-answer receiver must turn into a transmitter and then compete on priority with other pending buffers. The directed part of the bench builds both chains explicitly. The random part draws identifiers from a small pool, toggles the extended-format and remote flags, and switches between full and partial masks. This produces many near-miss keys, overruns and fallbacks to buffer 14. A bench-side model of every buffer predicts each filter result and each transmit choice.

// File: rtl/can_arb_pkg.sv
package can_arb_pkg;
  typedef enum logic [1:0] {
    BM_OFF = 2'd0,
    BM_RX  = 2'd1,
    BM_TX  = 2'd2
  } bmode_t;

  function automatic bmode_t decode_mode(input logic [1:0] code);
    case (code)
      2'd1:    return BM_RX;
      2'd2:    return BM_TX;
      default: return BM_OFF;
    endcase
  endfunction
endpackage

// File: rtl/can_stamp_ctr.sv
module can_stamp_ctr #(
  parameter int TS_W = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  output logic [TS_W-1:0] stamp
);
  always_ff @(posedge clk) begin
    if (!rst_n) stamp <= '0;
    else        stamp <= stamp + 1'b1;
  end
endmodule

// File: rtl/can_rx_match.sv
module can_rx_match #(
  parameter int NBUF  = 15,
  parameter int KEY_W = 31,
  localparam int IDX_W = $clog2(NBUF)
) (
  input  logic [KEY_W-1:0]            frame_key,
  input  logic [KEY_W-1:0]            mask_main,
  input  logic [KEY_W-1:0]            mask_basic,
  input  logic [NBUF-1:0]             cand,
  input  logic [NBUF-1:0][KEY_W-1:0]  keys,
  output logic                        hit,
  output logic [IDX_W-1:0]            hit_idx
);
  logic [NBUF-1:0] match;

  for (genvar g = 0; g < NBUF; g++) begin : g_cmp
    if (g == NBUF - 1) begin : g_basic
      assign match[g] = cand[g] && (((frame_key ^ keys[g]) & mask_basic) == '0);
    end else begin : g_main
      assign match[g] = cand[g] && (((frame_key ^ keys[g]) & mask_main) == '0);
    end
  end

  always_comb begin
    hit     = 1'b0;
    hit_idx = '0;
    for (int i = NBUF - 2; i >= 0; i--) begin
      if (match[i]) begin
        hit     = 1'b1;
        hit_idx = IDX_W'(i);
      end
    end
    if (!hit && match[NBUF-1]) begin
      hit     = 1'b1;
      hit_idx = IDX_W'(NBUF - 1);
    end
  end
endmodule

// File: rtl/can_tx_pick.sv
module can_tx_pick #(
  parameter int NBUF   = 15,
  parameter int PRIO_W = 4,
  localparam int IDX_W = $clog2(NBUF)
) (
  input  logic [NBUF-1:0]              pend,
  input  logic [NBUF-1:0][PRIO_W-1:0]  prio,
  output logic                         any,
  output logic [IDX_W-1:0]             idx
);
  logic [PRIO_W-1:0] best;

  always_comb begin
    any  = 1'b0;
    idx  = '0;
    best = '1;
    for (int i = 0; i < NBUF; i++) begin
      if (pend[i] && (!any || prio[i] < best)) begin
        any  = 1'b1;
        idx  = IDX_W'(i);
        best = prio[i];
      end
    end
  end
endmodule

// File: rtl/can_msgbuf_arbiter.sv
module can_msgbuf_arbiter
  import can_arb_pkg::*;
#(
  parameter int NBUF   = 15,
  parameter int ID_W   = 29,
  parameter int TS_W   = 16,
  parameter int PRIO_W = 4,
  localparam int IDX_W = $clog2(NBUF),
  localparam int KEY_W = ID_W + 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [IDX_W-1:0]  cfg_idx,
  input  logic [1:0]        cfg_mode,
  input  logic [ID_W-1:0]   cfg_id,
  input  logic              cfg_ide,
  input  logic              cfg_rtr,
  input  logic [PRIO_W-1:0] cfg_prio,
  input  logic              cfg_auto,
  input  logic              rel_we,
  input  logic [IDX_W-1:0]  rel_idx,
  input  logic [KEY_W-1:0]  mask_main,
  input  logic [KEY_W-1:0]  mask_basic,
  input  logic              rx_valid,
  output logic              rx_ready,
  input  logic [ID_W-1:0]   rx_id,
  input  logic              rx_ide,
  input  logic              rx_rtr,
  output logic              rx_res_valid,
  output logic              rx_res_hit,
  output logic [IDX_W-1:0]  rx_res_buf,
  output logic              tx_valid,
  input  logic              tx_ready,
  output logic [IDX_W-1:0]  tx_buf,
  output logic [ID_W-1:0]   tx_id,
  output logic              tx_ide,
  output logic              tx_rtr,
  input  logic              tx_done,
  input  logic              tx_lost,
  output logic [TS_W-1:0]   ts_now,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic [ID_W-1:0]   rd_id,
  output logic              rd_ide,
  output logic              rd_rtr,
  output logic [TS_W-1:0]   rd_stamp,
  output logic [NBUF-1:0]   buf_rx_full,
  output logic [NBUF-1:0]   buf_ovr,
  output logic [NBUF-1:0]   buf_tx_pend
);
  bmode_t            mode_q  [NBUF];
  logic [ID_W-1:0]   id_q    [NBUF];
  logic              ide_q   [NBUF];
  logic              rtr_q   [NBUF];
  logic [PRIO_W-1:0] prio_q  [NBUF];
  logic              auto_q  [NBUF];
  logic [TS_W-1:0]   stamp_q [NBUF];
  logic [NBUF-1:0]   full_q, ovr_q;

  logic              busy_q;
  logic [IDX_W-1:0]  busy_idx_q;
  logic              res_valid_q, res_hit_q;
  logic [IDX_W-1:0]  res_buf_q;

  logic [NBUF-1:0]              cand, pend;
  logic [NBUF-1:0][KEY_W-1:0]   keys;
  logic [NBUF-1:0][PRIO_W-1:0]  prios;
  logic [KEY_W-1:0]             frame_key;
  logic                         hit, pick_any;
  logic [IDX_W-1:0]             hit_idx, pick_idx;
  logic                         rx_fire, tx_fire;

  for (genvar g = 0; g < NBUF; g++) begin : g_view
    assign cand[g]  = (mode_q[g] == BM_RX);
    assign pend[g]  = (mode_q[g] == BM_TX);
    assign keys[g]  = {ide_q[g], rtr_q[g], id_q[g]};
    assign prios[g] = prio_q[g];
  end

  assign frame_key = {rx_ide, rx_rtr, rx_id};
  assign rx_ready  = !cfg_we;
  assign rx_fire   = rx_valid && rx_ready;

  can_stamp_ctr #(.TS_W(TS_W)) u_stamp (
    .clk   (clk),
    .rst_n (rst_n),
    .stamp (ts_now)
  );

  can_rx_match #(.NBUF(NBUF), .KEY_W(KEY_W)) u_match (
    .frame_key  (frame_key),
    .mask_main  (mask_main),
    .mask_basic (mask_basic),
    .cand       (cand),
    .keys       (keys),
    .hit        (hit),
    .hit_idx    (hit_idx)
  );

  can_tx_pick #(.NBUF(NBUF), .PRIO_W(PRIO_W)) u_pick (
    .pend (pend),
    .prio (prios),
    .any  (pick_any),
    .idx  (pick_idx)
  );

  assign tx_valid = pick_any && !busy_q;
  assign tx_buf   = pick_idx;
  assign tx_id    = id_q[pick_idx];
  assign tx_ide   = ide_q[pick_idx];
  assign tx_rtr   = rtr_q[pick_idx];
  assign tx_fire  = tx_valid && tx_ready;

  assign rx_res_valid = res_valid_q;
  assign rx_res_hit   = res_hit_q;
  assign rx_res_buf   = res_buf_q;

  assign rd_id    = id_q[rd_idx];
  assign rd_ide   = ide_q[rd_idx];
  assign rd_rtr   = rtr_q[rd_idx];
  assign rd_stamp = stamp_q[rd_idx];

  assign buf_rx_full = full_q;
  assign buf_ovr     = ovr_q;
  assign buf_tx_pend = pend;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NBUF; i++) begin
        mode_q[i]  <= BM_OFF;
        id_q[i]    <= '0;
        ide_q[i]   <= 1'b0;
        rtr_q[i]   <= 1'b0;
        prio_q[i]  <= '0;
        auto_q[i]  <= 1'b0;
        stamp_q[i] <= '0;
      end
      full_q      <= '0;
      ovr_q       <= '0;
      busy_q      <= 1'b0;
      busy_idx_q  <= '0;
      res_valid_q <= 1'b0;
      res_hit_q   <= 1'b0;
      res_buf_q   <= '0;
    end else begin
      res_valid_q <= rx_fire;
      res_hit_q   <= rx_fire && hit;
      res_buf_q   <= hit ? hit_idx : '0;

      if (cfg_we && int'(cfg_idx) < NBUF) begin
        mode_q[cfg_idx]  <= decode_mode(cfg_mode);
        id_q[cfg_idx]    <= cfg_id;
        ide_q[cfg_idx]   <= cfg_ide;
        rtr_q[cfg_idx]   <= cfg_rtr;
        prio_q[cfg_idx]  <= cfg_prio;
        auto_q[cfg_idx]  <= cfg_auto;
        full_q[cfg_idx]  <= 1'b0;
        ovr_q[cfg_idx]   <= 1'b0;
      end

      if (rel_we && int'(rel_idx) < NBUF) begin
        full_q[rel_idx] <= 1'b0;
        ovr_q[rel_idx]  <= 1'b0;
      end

      if (rx_fire && hit) begin
        id_q[hit_idx]    <= rx_id;
        ide_q[hit_idx]   <= rx_ide;
        stamp_q[hit_idx] <= ts_now;
        if (auto_q[hit_idx] && rx_rtr) begin
          mode_q[hit_idx] <= BM_TX;
          rtr_q[hit_idx]  <= 1'b0;
          full_q[hit_idx] <= 1'b0;
          ovr_q[hit_idx]  <= 1'b0;
        end else begin
          rtr_q[hit_idx]  <= rx_rtr;
          full_q[hit_idx] <= 1'b1;
          if (full_q[hit_idx]) ovr_q[hit_idx] <= 1'b1;
        end
      end

      if (tx_fire) begin
        busy_q     <= 1'b1;
        busy_idx_q <= pick_idx;
      end else if (busy_q && tx_done) begin
        busy_q              <= 1'b0;
        stamp_q[busy_idx_q] <= ts_now;
        full_q[busy_idx_q]  <= 1'b0;
        ovr_q[busy_idx_q]   <= 1'b0;
        if (rtr_q[busy_idx_q]) begin
          mode_q[busy_idx_q] <= BM_RX;
          rtr_q[busy_idx_q]  <= 1'b0;
        end else begin
          mode_q[busy_idx_q] <= BM_OFF;
        end
      end else if (busy_q && tx_lost) begin
        busy_q <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/can_arb_checker.sv
module can_arb_checker #(
  parameter int NBUF  = 15,
  parameter int TS_W  = 16,
  parameter int IDX_W = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             rx_valid,
  input logic             rx_ready,
  input logic             rx_res_valid,
  input logic             rx_res_hit,
  input logic [IDX_W-1:0] rx_res_buf,
  input logic             tx_valid,
  input logic             tx_ready,
  input logic [IDX_W-1:0] tx_buf,
  input logic [TS_W-1:0]  ts_now,
  input logic [NBUF-1:0]  buf_rx_full,
  input logic [NBUF-1:0]  buf_ovr,
  input logic [NBUF-1:0]  buf_tx_pend
);
  assert_result_after_take_R3: assert property (@(posedge clk) disable iff (!rst_n)
    rx_res_valid |-> $past(rx_valid && rx_ready));

  assert_hit_in_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
    rx_res_hit |-> (rx_res_valid && int'(rx_res_buf) < NBUF));

  assert_stamp_runs_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> (ts_now == TS_W'($past(ts_now) + 1'b1)));

  assert_offer_is_pending_R7: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid |-> buf_tx_pend[tx_buf]);

  assert_offer_drops_after_take_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && tx_ready) |=> !tx_valid);

  assert_no_overflow_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (buf_ovr & ~buf_rx_full) == '0);

  assert_roles_disjoint_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (buf_rx_full & buf_tx_pend) == '0);
endmodule

bind can_msgbuf_arbiter can_arb_checker #(
  .NBUF(NBUF), .TS_W(TS_W), .IDX_W(IDX_W)
) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .rx_valid     (rx_valid),
  .rx_ready     (rx_ready),
  .rx_res_valid (rx_res_valid),
  .rx_res_hit   (rx_res_hit),
  .rx_res_buf   (rx_res_buf),
  .tx_valid     (tx_valid),
  .tx_ready     (tx_ready),
  .tx_buf       (tx_buf),
  .ts_now       (ts_now),
  .buf_rx_full  (buf_rx_full),
  .buf_ovr      (buf_ovr),
  .buf_tx_pend  (buf_tx_pend)
);

// File: tb/can_msgbuf_arbiter_tb.sv
module can_msgbuf_arbiter_tb;
  localparam int NB = 15;

  logic clk = 0, rst_n = 0;
  always #10 clk = ~clk;

  logic        cfg_we = 0, cfg_ide = 0, cfg_rtr = 0, cfg_auto = 0;
  logic [3:0]  cfg_idx = 0, cfg_prio = 0, rel_idx = 0, rd_idx = 0;
  logic [1:0]  cfg_mode = 0;
  logic [28:0] cfg_id = 0, rx_id = 0;
  logic        rel_we = 0, rx_valid = 0, rx_ide = 0, rx_rtr = 0;
  logic [30:0] mask_main = '1, mask_basic = '1;
  logic        tx_ready = 0, tx_done = 0, tx_lost = 0;
  logic        rx_ready, rx_res_valid, rx_res_hit, tx_valid, tx_ide, tx_rtr, rd_ide, rd_rtr;
  logic [3:0]  rx_res_buf, tx_buf;
  logic [28:0] tx_id, rd_id;
  logic [15:0] ts_now, rd_stamp;
  logic [14:0] buf_rx_full, buf_ovr, buf_tx_pend;

  can_msgbuf_arbiter u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_idx(cfg_idx), .cfg_mode(cfg_mode),
    .cfg_id(cfg_id), .cfg_ide(cfg_ide), .cfg_rtr(cfg_rtr), .cfg_prio(cfg_prio),
    .cfg_auto(cfg_auto), .rel_we(rel_we), .rel_idx(rel_idx), .mask_main(mask_main),
    .mask_basic(mask_basic), .rx_valid(rx_valid), .rx_ready(rx_ready), .rx_id(rx_id),
    .rx_ide(rx_ide), .rx_rtr(rx_rtr), .rx_res_valid(rx_res_valid), .rx_res_hit(rx_res_hit),
    .rx_res_buf(rx_res_buf), .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_buf(tx_buf),
    .tx_id(tx_id), .tx_ide(tx_ide), .tx_rtr(tx_rtr), .tx_done(tx_done), .tx_lost(tx_lost),
    .ts_now(ts_now), .rd_idx(rd_idx), .rd_id(rd_id), .rd_ide(rd_ide), .rd_rtr(rd_rtr),
    .rd_stamp(rd_stamp), .buf_rx_full(buf_rx_full), .buf_ovr(buf_ovr),
    .buf_tx_pend(buf_tx_pend)
  );

  int checks = 0, failures = 0;
  bit finished = 0;

  // bench model: mode 0 off, 1 rx, 2 tx
  int          m_mode [NB];
  logic [28:0] m_id   [NB];
  logic        m_ide  [NB], m_rtr [NB], m_auto [NB], m_full [NB], m_ovr [NB];
  logic [3:0]  m_prio [NB];
  logic [15:0] m_stamp[NB];

  function automatic void chk(bit ok, string req, longint act, longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endfunction

  function automatic int exp_match(logic [28:0] id, logic ide, logic rtr);
    logic [30:0] k = {ide, rtr, id};
    for (int i = 0; i < NB - 1; i++)
      if (m_mode[i] == 1 && (((k ^ {m_ide[i], m_rtr[i], m_id[i]}) & mask_main) == 0)) return i;
    if (m_mode[NB-1] == 1 &&
        (((k ^ {m_ide[NB-1], m_rtr[NB-1], m_id[NB-1]}) & mask_basic) == 0)) return NB - 1;
    return -1;
  endfunction

  function automatic int exp_pick();
    int b = -1;
    for (int i = 0; i < NB; i++)
      if (m_mode[i] == 2 && (b < 0 || m_prio[i] < m_prio[b])) b = i;
    return b;
  endfunction

  function automatic void chk_vectors(string req);
    logic [14:0] f, o, p;
    for (int i = 0; i < NB; i++) begin
      f[i] = m_full[i]; o[i] = m_ovr[i]; p[i] = (m_mode[i] == 2);
    end
    chk(buf_rx_full == f, {req, " full"}, buf_rx_full, f);
    chk(buf_ovr == o, {req, " ovr"}, buf_ovr, o);
    chk(buf_tx_pend == p, {req, " pend"}, buf_tx_pend, p);
  endfunction

  task automatic cfg(int idx, int mode, logic [28:0] id, logic ide, logic rtr,
                     logic [3:0] prio, logic aut, bit probe_rx);
    @(negedge clk);
    cfg_we = 1; cfg_idx = 4'(idx); cfg_mode = 2'(mode); cfg_id = id;
    cfg_ide = ide; cfg_rtr = rtr; cfg_prio = prio; cfg_auto = aut;
    if (probe_rx) begin
      rx_valid = 1; rx_id = id; rx_ide = ide; rx_rtr = rtr;
    end
    #1 chk(rx_ready == 0, "R12 ready low during cfg", rx_ready, 0);
    @(negedge clk);
    cfg_we = 0; rx_valid = 0;
    if (probe_rx) chk(rx_res_valid == 0, "R12 frame ignored", rx_res_valid, 0);
    m_mode[idx] = (mode == 1 || mode == 2) ? mode : 0;
    m_id[idx] = id; m_ide[idx] = ide; m_rtr[idx] = rtr; m_prio[idx] = prio;
    m_auto[idx] = aut; m_full[idx] = 0; m_ovr[idx] = 0;
  endtask

  task automatic send_rx(logic [28:0] id, logic ide, logic rtr, string req);
    int e;
    logic [15:0] t;
    @(negedge clk);
    rx_valid = 1; rx_id = id; rx_ide = ide; rx_rtr = rtr;
    e = exp_match(id, ide, rtr);
    t = ts_now;
    #1 chk(rx_ready == 1, {req, " ready"}, rx_ready, 1);
    @(negedge clk);
    rx_valid = 0;
    chk(rx_res_valid == 1, {req, " res valid"}, rx_res_valid, 1);
    chk(rx_res_hit == (e >= 0), {req, " hit"}, rx_res_hit, e >= 0);
    if (e >= 0) begin
      chk(int'(rx_res_buf) == e, {req, " buf"}, rx_res_buf, e);
      m_id[e] = id; m_ide[e] = ide; m_stamp[e] = t;
      if (m_auto[e] && rtr) begin
        m_mode[e] = 2; m_rtr[e] = 0; m_full[e] = 0; m_ovr[e] = 0;
      end else begin
        m_rtr[e] = rtr; m_ovr[e] = m_ovr[e] | m_full[e]; m_full[e] = 1;
      end
      rd_idx = 4'(e);
      #1;
      chk(rd_stamp == t, "R11 rx stamp", rd_stamp, t);
      chk(rd_id == id, {req, " stored id"}, rd_id, id);
    end
    chk_vectors(req);
  endtask

  task automatic tx_round(bit lose, string req);
    int e;
    logic [15:0] t;
    @(negedge clk);
    e = exp_pick();
    chk(tx_valid == (e >= 0), {req, " R7 valid"}, tx_valid, e >= 0);
    if (e < 0) return;
    chk(int'(tx_buf) == e, {req, " R7 pick"}, tx_buf, e);
    chk(tx_id == m_id[e], {req, " R7 id"}, tx_id, m_id[e]);
    tx_ready = 1;
    @(negedge clk);
    tx_ready = 0;
    chk(tx_valid == 0, {req, " R8 in flight"}, tx_valid, 0);
    if (lose) tx_lost = 1; else tx_done = 1;
    t = ts_now;
    @(negedge clk);
    tx_lost = 0; tx_done = 0;
    if (!lose) begin
      m_stamp[e] = t; m_full[e] = 0; m_ovr[e] = 0;
      if (m_rtr[e]) begin m_mode[e] = 1; m_rtr[e] = 0; end
      else m_mode[e] = 0;
      rd_idx = 4'(e);
      #1 chk(rd_stamp == t, "R8 tx stamp", rd_stamp, t);
    end
    chk_vectors(req);
  endtask

  task automatic release_buf(int idx);
    @(negedge clk);
    rel_we = 1; rel_idx = 4'(idx);
    @(negedge clk);
    rel_we = 0;
    m_full[idx] = 0; m_ovr[idx] = 0;
    chk_vectors("R13 release");
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!finished) begin
      failures++; checks++;
      $display("FAIL watchdog actual=1 expected=0");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin : main
    logic [28:0] pool [4];
    void'($urandom(32'd4711));
    for (int i = 0; i < NB; i++) begin
      m_mode[i] = 0; m_id[i] = 0; m_ide[i] = 0; m_rtr[i] = 0; m_auto[i] = 0;
      m_full[i] = 0; m_ovr[i] = 0; m_prio[i] = 0; m_stamp[i] = 0;
    end
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(ts_now == 0, "R1 stamp", ts_now, 0);
    chk(tx_valid == 0, "R1 tx_valid", tx_valid, 0);
    chk(rx_res_valid == 0, "R1 res", rx_res_valid, 0);
    chk_vectors("R1");
    rst_n = 1;
    @(negedge clk);
    chk(ts_now == 1, "R11 counting", ts_now, 1);

    // R2 / R3 exact match and lowest index
    cfg(5, 1, 29'h123, 0, 0, 0, 0, 0);
    cfg(3, 1, 29'h123, 0, 0, 0, 0, 0);
    send_rx(29'h123, 0, 0, "R3 lowest index");
    send_rx(29'h124, 0, 0, "R5 miss");
    send_rx(29'h123, 1, 0, "R2 ide compared");
    mask_main = 31'h7FFF_FFF8;
    send_rx(29'h125, 0, 0, "R2 masked bits ignored");
    chk(buf_ovr[3] == 1, "R6 overrun flag", buf_ovr[3], 1);
    release_buf(3);
    send_rx(29'h126, 0, 0, "R6 fresh store");
    mask_main = '1;
    // R4 catch-all
    cfg(14, 1, 29'h0, 0, 0, 0, 0, 1);
    mask_basic = '0;
    send_rx(29'h7FF, 0, 0, "R4 catch-all");
    send_rx(29'h123, 0, 0, "R4 main wins");
    mask_basic = '1;
    // R7 / R8 priority and lost arbitration
    cfg(9, 2, 29'h90, 0, 0, 4'd5, 0, 0);
    cfg(2, 2, 29'h20, 0, 0, 4'd5, 0, 0);
    cfg(11, 2, 29'hB0, 1, 0, 4'd1, 0, 0);
    tx_round(0, "R7 urgent first");
    tx_round(1, "R8 lost keeps pending");
    tx_round(0, "R7 tie lower index");
    tx_round(0, "R8 last");
    tx_round(0, "R7 none pending");
    // R9 remote request then answer
    cfg(4, 2, 29'h55, 0, 1, 4'd0, 0, 0);
    tx_round(0, "R9 remote sent");
    chk(m_mode[4] == 1, "R9 model", m_mode[4], 1);
    send_rx(29'h55, 0, 0, "R9 answer lands");
    // R10 auto answer
    cfg(6, 1, 29'h66, 0, 1, 4'd2, 1, 0);
    send_rx(29'h66, 0, 1, "R10 remote triggers");
    tx_round(0, "R10 answer sent");

    // random phase
    for (int i = 0; i < 4; i++) pool[i] = 29'($urandom) & (i[0] ? 29'h1FFF_FFFF : 29'h7FF);
    for (int it = 0; it < 400; it++) begin
      int op = $urandom % 10;
      int b = $urandom % NB;
      int p = $urandom % 4;
      if (op < 2) begin
        int md = 1 + ($urandom % 2);
        cfg(b, md, pool[p], 1'(p % 2), 1'($urandom % 4 == 0), 4'($urandom % 4),
            1'($urandom % 3 == 0), 0);
      end else if (op < 6) begin
        logic [28:0] id = pool[p] ^ (($urandom % 3 == 0) ? 29'(1 << ($urandom % 3)) : 29'h0);
        send_rx(id, 1'(p % 2), 1'($urandom % 5 == 0), "R2 random frame");
      end else if (op < 8) begin
        tx_round(1'($urandom % 4 == 0), "R7 random tx");
      end else if (op == 8) begin
        release_buf(b);
      end else begin
        mask_main  = ($urandom % 2) ? '1 : 31'h7FFF_FFF8;
        mask_basic = ($urandom % 2) ? '1 : 31'h0;
      end
    end
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule